// File: doc/BRIEF.md
# Transmit Descriptor Status and Retry Control

This block holds the status word of a single transmit descriptor and makes the start, retry and abort decisions for a half-duplex transmitter. Software writes a descriptor word that carries a 13-bit byte count, a 6-bit early-start code and an ownership flag. Clearing the ownership flag arms the descriptor. The block then watches the fill level of the transmit FIFO and requests a start once enough bytes are present, or once the FIFO holds a whole frame.

While a frame is on the wire, the block counts collisions and asks for a retransmission after each one, up to a programmable limit. It records how the attempt ended as a set of sticky flags in the status word: success, underrun, abort, carrier loss, late collision and missing heartbeat. An abort parks the block until a clear-abort command retransmits the same descriptor. Medium-access timing and backoff are handled outside the block.

Top module: `txd_ctrl`

## Requirements
- R1: A descriptor write stores the byte count in status bits 12:0, the early-start code in bits 21:16 and the ownership flag in bit 13. The values read back in the status word one cycle later. Bits 23:22 read 0. Writing the ownership flag as 0 arms the descriptor; writing it as 1 leaves the block idle.
- R2: An armed descriptor raises tx_start when fifo_level reaches the threshold or when pkt_complete is high. The threshold is 8 bytes for code 0 and code×32 bytes for codes 1..63. A level one byte below the threshold does not start.
- R3: Every descriptor write clears status bits 31:24, 15 and 14. Values written to those bit positions are ignored.
- R4: Each collision during transmission adds one to the collision field (bits 27:24, the number of collisions modulo 16). Unless the limit is reached, the block also requests a retransmission with a tx_start pulse.
- R5: With retry field N, 16+16×N retransmissions are allowed. The next collision aborts the attempt: it sets bit 30 and pulses tx_abort together with tx_done while tx_done_ok is 0.
- R6: clr_abort retransmits only in the aborted state. It then clears bit 30 and the collision counts and pulses tx_start. In any other state clr_abort has no effect.
- R7: The end of a transmission pulses tx_done with tx_done_ok = 1. Without an underrun it sets bit 15. If an underrun occurred during the attempt, it sets bit 14 instead and leaves bit 15 at 0.
- R8: Reset leaves the status word at 0x0000_2000: ownership set, every other bit 0. All pulse outputs are 0 after reset. dma_done sets bit 13.
- R9: During transmission, carrier loss sets bit 31 and a late collision sets bit 29. A missing heartbeat sets bit 28 only when speed_100 is low. Bit 28 is cleared in any cycle that follows one with speed_100 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_data | input | 32 | Descriptor write data |
| retry_field | input | 4 | Retry scaling field N |
| speed_100 | input | 1 | High in 100 Mb/s mode |
| fifo_level | input | 12 | Bytes in transmit FIFO |
| pkt_complete | input | 1 | FIFO holds a complete frame |
| dma_done | input | 1 | Descriptor DMA complete pulse |
| coll_evt | input | 1 | Collision pulse |
| late_coll_evt | input | 1 | Out-of-window collision pulse |
| crs_lost_evt | input | 1 | Carrier lost pulse |
| hb_miss_evt | input | 1 | Heartbeat missing pulse |
| underrun_evt | input | 1 | FIFO underrun pulse |
| tx_end | input | 1 | Frame finished on the wire |
| clr_abort | input | 1 | Clear-abort command pulse |
| status_word | output | 32 | Descriptor status read value |
| tx_start | output | 1 | Start or retransmit request pulse |
| tx_abort | output | 1 | Abort pulse |
| tx_done | output | 1 | Completion pulse |
| tx_done_ok | output | 1 | Completion was successful |

## Verification
Some properties are checked on every cycle. An abort always comes with a failed completion and a set abort flag. The success and underrun flags are never both set. A write always clears the sticky flags, a DMA completion always sets ownership, and the 100 Mb/s mode always clears the heartbeat flag. Each accepted collision steps the collision field by exactly one. The threshold arithmetic, the exact collision on which an abort occurs for each retry setting, the refusal of clear-abort outside the aborted state and the start-request counts can only be shown by the bench's scenarios against its reference model.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int SIZE_W     = 13;
  localparam int THR_W      = 6;
  localparam int RETRY_W    = 4;
  localparam int NCC_W      = 4;
  localparam int LVL_W      = 12;
  localparam int THR_MIN    = 8;
  localparam int THR_UNIT   = 32;
  localparam int RETRY_STEP = 16;
  localparam int RTX_W      = $clog2(RETRY_STEP * (2 ** RETRY_W)) + 1;

  localparam int POS_OWN  = 13;
  localparam int POS_TUN  = 14;
  localparam int POS_TOK  = 15;
  localparam int POS_THR  = 16;
  localparam int POS_NCC  = 24;
  localparam int POS_CDH  = 28;
  localparam int POS_OWC  = 29;
  localparam int POS_TABT = 30;
  localparam int POS_CRS  = 31;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_XMIT    = 2'd2,
    ST_ABORTED = 2'd3
  } txd_state_e;

  // Early-start threshold in bytes for a given code
  function automatic logic [LVL_W-1:0] thr_bytes(input logic [THR_W-1:0] code);
    if (code == '0) return LVL_W'(THR_MIN);
    return LVL_W'(int'(code) * THR_UNIT);
  endfunction

  // Retransmissions allowed before the next collision aborts
  function automatic logic [RTX_W-1:0] retry_limit(input logic [RETRY_W-1:0] field);
    return RTX_W'((int'(field) + 1) * RETRY_STEP);
  endfunction
endpackage

// File: rtl/txd_start_gate.sv
module txd_start_gate
  import txd_pkg::*;
(
  input  logic             armed,
  input  logic [THR_W-1:0] code,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             pkt_complete,
  output logic             go
);
  logic [LVL_W-1:0] need;
  always_comb begin
    need = thr_bytes(code);
    go   = armed && (pkt_complete || (fifo_level >= need));
  end
endmodule

// File: rtl/txd_retry_ctr.sv
module txd_retry_ctr
  import txd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               coll,
  input  logic [RETRY_W-1:0] field,
  output logic               at_limit,
  output logic [NCC_W-1:0]   ncc
);
  logic [RTX_W-1:0] rtx_q;
  logic [NCC_W-1:0] ncc_q;

  assign at_limit = (rtx_q == retry_limit(field));
  assign ncc      = ncc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtx_q <= '0;
      ncc_q <= '0;
    end else if (clr) begin
      rtx_q <= '0;
      ncc_q <= '0;
    end else if (coll) begin
      ncc_q <= ncc_q + 1'b1;
      if (!at_limit) rtx_q <= rtx_q + 1'b1;
    end
  end
endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
  import txd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic [RETRY_W-1:0] retry_field,
  input  logic               speed_100,
  input  logic [LVL_W-1:0]   fifo_level,
  input  logic               pkt_complete,
  input  logic               dma_done,
  input  logic               coll_evt,
  input  logic               late_coll_evt,
  input  logic               crs_lost_evt,
  input  logic               hb_miss_evt,
  input  logic               underrun_evt,
  input  logic               tx_end,
  input  logic               clr_abort,
  output logic [31:0]        status_word,
  output logic               tx_start,
  output logic               tx_abort,
  output logic               tx_done,
  output logic               tx_done_ok
);
  txd_state_e        st_q;
  logic [SIZE_W-1:0] size_q;
  logic [THR_W-1:0]  thr_q;
  logic              own_q, crs_q, tabt_q, owc_q, cdh_q, tok_q, tun_q, uflag_q;
  logic              start_q, abort_q, done_q, ok_q;
  logic [NCC_W-1:0]  ncc;
  logic              at_limit, gate_go;

  // Named internal events (all suppressed by a descriptor write)
  logic in_xmit, ev_go, ev_end, ev_coll, ev_abort, ev_retry, ev_clr, ctr_clr;
  assign in_xmit  = (st_q == ST_XMIT) && !wr_en;
  assign ev_go    = gate_go && !wr_en;
  assign ev_end   = in_xmit && tx_end;
  assign ev_coll  = in_xmit && coll_evt && !tx_end;
  assign ev_abort = ev_coll && at_limit;
  assign ev_retry = ev_coll && !at_limit;
  assign ev_clr   = (st_q == ST_ABORTED) && clr_abort && !wr_en;
  assign ctr_clr  = wr_en || ev_clr;

  txd_start_gate u_gate (
    .armed       (st_q == ST_ARMED),
    .code        (thr_q),
    .fifo_level  (fifo_level),
    .pkt_complete(pkt_complete),
    .go          (gate_go)
  );

  txd_retry_ctr u_retry (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctr_clr),
    .coll    (ev_coll),
    .field   (retry_field),
    .at_limit(at_limit),
    .ncc     (ncc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      size_q  <= '0;
      thr_q   <= '0;
      own_q   <= 1'b1;
      crs_q   <= 1'b0;
      tabt_q  <= 1'b0;
      owc_q   <= 1'b0;
      cdh_q   <= 1'b0;
      tok_q   <= 1'b0;
      tun_q   <= 1'b0;
      uflag_q <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      start_q <= ev_go || ev_retry || ev_clr;
      abort_q <= ev_abort;
      done_q  <= ev_abort || ev_end;
      ok_q    <= ev_end;
      if (wr_en) begin
        size_q  <= wr_data[SIZE_W-1:0];
        thr_q   <= wr_data[POS_THR +: THR_W];
        own_q   <= wr_data[POS_OWN];
        crs_q   <= 1'b0;
        tabt_q  <= 1'b0;
        owc_q   <= 1'b0;
        cdh_q   <= 1'b0;
        tok_q   <= 1'b0;
        tun_q   <= 1'b0;
        uflag_q <= 1'b0;
        st_q    <= wr_data[POS_OWN] ? ST_IDLE : ST_ARMED;
      end else begin
        if (ev_go) st_q <= ST_XMIT;
        if (ev_abort) begin
          tabt_q <= 1'b1;
          st_q   <= ST_ABORTED;
        end
        if (ev_end) begin
          st_q <= ST_IDLE;
          if (uflag_q) tun_q <= 1'b1;
          else         tok_q <= 1'b1;
        end
        if (ev_clr) begin
          tabt_q <= 1'b0;
          st_q   <= ST_XMIT;
        end
        if (in_xmit && underrun_evt)  uflag_q <= 1'b1;
        if (in_xmit && crs_lost_evt)  crs_q   <= 1'b1;
        if (in_xmit && late_coll_evt) owc_q   <= 1'b1;
        if (in_xmit && hb_miss_evt && !speed_100) cdh_q <= 1'b1;
      end
      if (dma_done)  own_q <= 1'b1;
      if (speed_100) cdh_q <= 1'b0;
    end
  end

  always_comb begin
    status_word                       = '0;
    status_word[SIZE_W-1:0]           = size_q;
    status_word[POS_OWN]              = own_q;
    status_word[POS_TUN]              = tun_q;
    status_word[POS_TOK]              = tok_q;
    status_word[POS_THR +: THR_W]     = thr_q;
    status_word[POS_NCC +: NCC_W]     = ncc;
    status_word[POS_CDH]              = cdh_q;
    status_word[POS_OWC]              = owc_q;
    status_word[POS_TABT]             = tabt_q;
    status_word[POS_CRS]              = crs_q;
  end

  assign tx_start   = start_q;
  assign tx_abort   = abort_q;
  assign tx_done    = done_q;
  assign tx_done_ok = ok_q;
endmodule

// File: rtl/txd_checker.sv
module txd_checker
  import txd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        dma_done,
  input logic        speed_100,
  input logic        ev_coll,
  input logic [31:0] status_word,
  input logic        tx_abort,
  input logic        tx_done,
  input logic        tx_done_ok
);
  AST_ABORT_IS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (tx_done && !tx_done_ok)); // R5
  AST_ABORT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> status_word[POS_TABT]); // R5
  AST_OK_UNDERRUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_word[POS_TOK] && status_word[POS_TUN])); // R7
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (status_word[31:24] == 8'h00 && status_word[POS_TOK] == 1'b0
               && status_word[POS_TUN] == 1'b0)); // R3
  AST_DMA_SETS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> status_word[POS_OWN]); // R8
  AST_HB_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    speed_100 |=> !status_word[POS_CDH]); // R9
  AST_NCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_coll |=> (status_word[POS_NCC +: NCC_W] ==
                 NCC_W'($past(status_word[POS_NCC +: NCC_W]) + 1'b1))); // R4
endmodule

bind txd_ctrl txd_checker u_txd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .dma_done   (dma_done),
  .speed_100  (speed_100),
  .ev_coll    (ev_coll),
  .status_word(status_word),
  .tx_abort   (tx_abort),
  .tx_done    (tx_done),
  .tx_done_ok (tx_done_ok)
);

// File: tb/test_txd_ctrl.sv
`timescale 1ns/1ps
module test_txd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  retry_field = '0;
  logic        speed_100 = 1'b0;
  logic [11:0] fifo_level = '0;
  logic        pkt_complete = 1'b0, dma_done = 1'b0, coll_evt = 1'b0;
  logic        late_coll_evt = 1'b0, crs_lost_evt = 1'b0, hb_miss_evt = 1'b0;
  logic        underrun_evt = 1'b0, tx_end = 1'b0, clr_abort = 1'b0;
  logic [31:0] status_word;
  logic        tx_start, tx_abort, tx_done, tx_done_ok;

  int n_checks = 0, n_fail = 0;
  int cnt_start = 0, cnt_abort = 0, cnt_done = 0, cnt_ok = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txd_ctrl i_txd_ctrl (.*);

  // ---------------- reference model ----------------
  int m_st = 0, m_size = 0, m_thr = 0, m_coll = 0, m_rtx = 0;
  bit m_own = 1, m_crs = 0, m_tabt = 0, m_owc = 0, m_cdh = 0, m_tok = 0, m_tun = 0, m_uf = 0;
  bit m_start = 0, m_abort = 0, m_done = 0, m_ok = 0;

  function automatic logic [31:0] m_status();
    logic [31:0] s;
    s = '0;
    s[12:0] = 13'(m_size); s[13] = m_own; s[14] = m_tun; s[15] = m_tok;
    s[21:16] = 6'(m_thr); s[27:24] = 4'(m_coll % 16);
    s[28] = m_cdh; s[29] = m_owc; s[30] = m_tabt; s[31] = m_crs;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_size = 0; m_thr = 0; m_coll = 0; m_rtx = 0; m_own = 1;
      m_crs = 0; m_tabt = 0; m_owc = 0; m_cdh = 0; m_tok = 0; m_tun = 0; m_uf = 0;
      m_start = 0; m_abort = 0; m_done = 0; m_ok = 0;
    end else begin
      int need, lim, old_st;
      bit sending, hit_end, hit_coll;
      old_st = m_st;
      need = (m_thr == 0) ? 8 : m_thr * 32;
      lim = 16 + 16 * int'(retry_field);
      sending = (old_st == 2);
      hit_end = sending && tx_end;
      hit_coll = sending && coll_evt && !tx_end;
      m_start = 0; m_abort = 0; m_done = 0; m_ok = 0;
      if (wr_en) begin
        m_size = int'(wr_data[12:0]); m_thr = int'(wr_data[21:16]); m_own = wr_data[13];
        m_crs = 0; m_tabt = 0; m_owc = 0; m_cdh = 0; m_tok = 0; m_tun = 0; m_uf = 0;
        m_coll = 0; m_rtx = 0;
        m_st = wr_data[13] ? 0 : 1;
      end else begin
        if (old_st == 1 && (pkt_complete || int'(fifo_level) >= need)) begin
          m_st = 2; m_start = 1;
        end
        if (hit_coll) begin
          if (m_rtx == lim) begin
            m_tabt = 1; m_st = 3; m_abort = 1; m_done = 1;
          end else begin
            m_rtx++; m_start = 1;
          end
          m_coll++;
        end
        if (hit_end) begin
          m_done = 1; m_ok = 1; m_st = 0;
          if (m_uf) m_tun = 1; else m_tok = 1;
        end
        if (old_st == 3 && clr_abort) begin
          m_tabt = 0; m_coll = 0; m_rtx = 0; m_start = 1; m_st = 2;
        end
        if (sending && underrun_evt) m_uf = 1;
        if (sending && crs_lost_evt) m_crs = 1;
        if (sending && late_coll_evt) m_owc = 1;
        if (sending && hb_miss_evt && !speed_100) m_cdh = 1;
      end
      if (dma_done) m_own = 1;
      if (speed_100) m_cdh = 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R3 status vs model", status_word, m_status());
      check("R2 tx_start vs model", 32'(tx_start), 32'(m_start));
      check("R5 tx_abort vs model", 32'(tx_abort), 32'(m_abort));
      check("R7 tx_done vs model", {30'd0, tx_done, tx_done_ok}, {30'd0, m_done, m_ok});
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_start) cnt_start++;
      if (tx_abort) cnt_abort++;
      if (tx_done) cnt_done++;
      if (tx_done && tx_done_ok) cnt_ok++;
    end
  end

  function automatic logic [31:0] wd(int size, int thr, bit own);
    return {10'd0, 6'(thr), 2'b00, own, 13'(size)};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_desc(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  // 0 coll,1 end,2 underrun,3 crs,4 owc,5 hb,6 dma,7 clr_abort,8 pkt_complete
  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: coll_evt = 1'b1;      1: tx_end = 1'b1;        2: underrun_evt = 1'b1;
      3: crs_lost_evt = 1'b1;  4: late_coll_evt = 1'b1; 5: hb_miss_evt = 1'b1;
      6: dma_done = 1'b1;      7: clr_abort = 1'b1;     default: pkt_complete = 1'b1;
    endcase
    @(negedge clk);
    coll_evt = 0; tx_end = 0; underrun_evt = 0; crs_lost_evt = 0; late_coll_evt = 0;
    hb_miss_evt = 0; dma_done = 0; clr_abort = 0; pkt_complete = 0;
  endtask

  task automatic kick();
    @(negedge clk); fifo_level = 12'd8;
    @(negedge clk); fifo_level = 12'd0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int s0, a0, d0, k0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R8 reset status", status_word, 32'h0000_2000);
    check("R8 reset pulses", {28'd0, tx_start, tx_abort, tx_done, tx_done_ok}, 32'd0);

    // R1 and R2 with code 0 (8 bytes)
    write_desc(wd(100, 0, 0));
    check("R1 readback", status_word, wd(100, 0, 0));
    fifo_level = 12'd7; idle(3);
    check("R2 below 8 bytes no start", 32'(cnt_start), 32'd0);
    fifo_level = 12'd8; idle(3);
    check("R2 start at 8 bytes", 32'(cnt_start), 32'd1);
    fifo_level = 12'd0;
    pulse(1); idle(2);
    check("R7 ok bit", 32'(status_word[15:14]), 32'd2);
    check("R7 done ok count", {16'(cnt_done), 16'(cnt_ok)}, {16'd1, 16'd1});
    pulse(6); idle(1);
    check("R8 dma sets own", 32'(status_word[13]), 32'd1);

    // R2 code 3 (96 bytes), complete-frame start; R7 underrun
    write_desc(wd(200, 3, 0));
    fifo_level = 12'd95; idle(3);
    check("R2 95 of 96 no start", 32'(cnt_start), 32'd1);
    pulse(8); idle(2);
    check("R2 complete frame start", 32'(cnt_start), 32'd2);
    fifo_level = 12'd0;
    pulse(2); pulse(1); idle(2);
    check("R7 underrun bits", 32'(status_word[15:14]), 32'd1);
    check("R7 underrun done ok", 32'(cnt_ok), 32'd2);

    // R4 collisions and R9 flags
    write_desc(wd(60, 0, 0));
    s0 = cnt_start;
    kick();
    repeat (3) pulse(0);
    idle(2);
    check("R4 collision field", 32'(status_word[27:24]), 32'd3);
    check("R4 retransmit starts", 32'(cnt_start - s0), 32'd4);
    pulse(5); pulse(3); pulse(4); idle(1);
    check("R9 crs owc hb bits", 32'(status_word[31:28]), 32'hB);
    speed_100 = 1'b1; idle(2);
    check("R9 hb cleared at 100M", 32'(status_word[28]), 32'd0);
    pulse(5); idle(1);
    check("R9 hb ignored at 100M", 32'(status_word[28]), 32'd0);
    speed_100 = 1'b0;
    pulse(1); idle(2);

    // R6 clr_abort outside abort state ignored
    s0 = cnt_start;
    pulse(7); idle(2);
    check("R6 clr_abort ignored when idle", 32'(cnt_start - s0), 32'd0);

    // R5 retry field 0: 17th collision aborts
    write_desc(wd(64, 0, 0));
    kick();
    a0 = cnt_abort; d0 = cnt_done; k0 = cnt_ok;
    repeat (16) pulse(0);
    idle(2);
    check("R5 no abort after 16", 32'(cnt_abort - a0), 32'd0);
    pulse(0); idle(2);
    check("R5 abort on 17th", 32'(cnt_abort - a0), 32'd1);
    check("R5 abort flag and field", {status_word[30], 3'd0, status_word[27:24]}, 8'h81);
    check("R5 abort done not ok", {16'(cnt_done - d0), 16'(cnt_ok - k0)}, {16'd1, 16'd0});
    s0 = cnt_start;
    pulse(7); idle(2);
    check("R6 clr_abort retransmits", 32'(cnt_start - s0), 32'd1);
    check("R6 flag and field cleared", {status_word[30], 3'd0, status_word[27:24]}, 8'h00);
    pulse(1); idle(2);
    check("R7 ok after retransmit", 32'(status_word[15]), 32'd1);

    // R5 retry field 1: 33rd collision aborts
    retry_field = 4'd1;
    write_desc(wd(64, 0, 0));
    kick();
    a0 = cnt_abort;
    repeat (32) pulse(0);
    idle(2);
    check("R5 no abort after 32", {16'(cnt_abort - a0), 12'd0, status_word[27:24]}, 32'd0);
    pulse(0); idle(2);
    check("R5 abort on 33rd", 32'(cnt_abort - a0), 32'd1);

    // R3 write clears flags, written status bits ignored
    write_desc(32'hFFFF_FFFF);
    idle(1);
    check("R3 status bits cleared", status_word, 32'h003F_3FFF);

    idle(3);
    summary();
  end
endmodule